// File: doc/BRIEF.md
# Serial FIFO Trigger Interrupt Unit

This unit sits between a register bus and the bit-shifting engine of a serial master. It holds one transmit FIFO and one receive FIFO of 32 bytes each. Software fills the transmit side and drains the receive side through window registers. The engine pulls transmit words and pushes received words through a small strobe interface. Fill levels are always reported in bytes. In 16-bit mode each word counts as two, so the same 32 bytes of storage hold 16 words.

The unit also keeps a status register of event bits. These are a receive-count trigger, a transmit low-water trigger, transfer end, transmit end, overflow and underrun. Software clears any of them by writing a one. Each status bit has an enable bit at the same position in the control register, and the enabled bits are ORed into a single interrupt line. The receive trigger fires once the receive FIFO holds at least 2^code words, where the code is a 3-bit field.

Register bus reads are registered: the data for a read strobed in one cycle appears on the read-data port in the next cycle and is zero otherwise. Register offsets: mode 0x00, control 0x08, status 0x0C, receive level 0x10, transmit level 0x14, receive window 0x18, transmit window 0x1C, trigger 0x20.

Top module: `serfifo_trig`

## Requirements
- R1: After reset both FIFOs are empty, the mode, control, trigger and status registers read zero, `irq` is low and `regRdData` is zero.
- R2: A write to 0x1C pushes one word, keeping bits 7:0 when mode bit 0 is 0 and bits 15:0 when it is 1. Reading 0x14 returns the transmit level in bytes, that is, the word count in 8-bit mode or twice the word count in 16-bit mode. Capacity is 32 bytes, and a write to a full FIFO is ignored.
- R3: When `engTxReq` is high and the transmit FIFO is not empty, the oldest word is removed. `engTxWord` always shows the oldest word, or zero when the FIFO is empty.
- R4: When `engRxValid` is high, `engRxWord` is pushed (low byte only in 8-bit mode) unless the FIFO is full, in which case the word is dropped. A read of 0x18 returns the oldest word and removes it, and a read of an empty FIFO returns zero. Reading 0x10 returns the receive level in bytes.
- R5: A write of any value to 0x10 empties the receive FIFO, and a write to 0x14 empties the transmit FIFO. The flush takes precedence over a push or pop in the same cycle.
- R6: Status bit 0 is set in the cycle after one in which control bit 19 is 1 and the receive FIFO holds at least 2^code words, where code is trigger register bits 2:0. Codes 5, 6 and 7 all mean 32 words. The bit is forced to 0 in the cycle after any cycle in which control bit 19 is 0.
- R7: Status bit 4 is set in the cycle after one in which the transmit level is 16 bytes or less.
- R8: Status bit 8 is set after an `engXferEnd` pulse. Status bit 9 is set after the engine removes the last word from the transmit FIFO.
- R9: Status bit 12 (overflow) is set after `engRxValid` arrives while the receive FIFO is full and mode bit 1 (send-and-receive) is 1. In receive-only mode the dropped word raises no flag.
- R10: Status bit 13 (underrun) is set after `engTxReq` arrives while the transmit FIFO is empty and both mode bit 2 (run) and mode bit 1 are 1.
- R11: Writing 0x0C clears each status bit whose write-data bit is 1. A set event in the same cycle wins over the clear.
- R12: The control register at 0x08 stores bits 0, 4, 8, 9, 12, 13 (interrupt enables) and bit 19 (trigger enable), and reads them back. `irq` is high exactly when some status bit and its enable at the same position are both 1.
- R13: A read of an unmapped offset, or of the write-only window 0x1C, returns zero. Mode (bits 2:0) and trigger (bits 2:0) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register byte offset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after `regRd` |
| engTxReq | input | 1 | Engine takes one transmit word |
| engTxWord | output | 16 | Oldest transmit word |
| engRxValid | input | 1 | Engine delivers one received word |
| engRxWord | input | 16 | Received word |
| engXferEnd | input | 1 | Engine transfer-end pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with its defaults: a 32-byte FIFO depth and a 16-byte transmit low mark. With these values a full FIFO is reached after only 32 narrow or 16 wide pushes, so the bench can drive overflow, drop-on-full and ignored writes within a few dozen cycles. Every trigger code is also within reach, including the clamped 32-word codes. The low mark sits in the middle of the FIFO, so the transmit trigger is seen both held and released as the FIFO fills and drains. Directed phases are followed by long random runs in 8-bit and in 16-bit mode, and a queue model is compared against the outputs on every cycle.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
  // register offsets
  localparam logic [5:0] OFS_MODE  = 6'h00;
  localparam logic [5:0] OFS_CTRL  = 6'h08;
  localparam logic [5:0] OFS_STAT  = 6'h0C;
  localparam logic [5:0] OFS_RXLVL = 6'h10;
  localparam logic [5:0] OFS_TXLVL = 6'h14;
  localparam logic [5:0] OFS_RXWIN = 6'h18;
  localparam logic [5:0] OFS_TXWIN = 6'h1C;
  localparam logic [5:0] OFS_TRG   = 6'h20;

  // status / enable bit positions
  localparam int B_RXTRG = 0;
  localparam int B_TXTRG = 4;
  localparam int B_XEND  = 8;
  localparam int B_TXEND = 9;
  localparam int B_OVF   = 12;
  localparam int B_UDR   = 13;
  localparam int B_TRGEN = 19;

  // mode bit positions
  localparam int M_WIDE   = 0;
  localparam int M_DUPLEX = 1;
  localparam int M_RUN    = 2;

  localparam logic [31:0] STAT_MASK = 32'h0000_3311;
  localparam logic [31:0] CTRL_MASK = STAT_MASK | 32'h0008_0000;

  typedef struct packed {
    logic txPush;
    logic txFlush;
    logic rxPop;
    logic rxFlush;
    logic wide;
  } fifoStrobes_t;
endpackage

// File: rtl/serfifo_fifo.sv
module serfifo_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [CNT_W-1:0] capWords,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic pushOk, popOk;

  assign pushOk   = push && !flush && (count < capWords);
  assign popOk    = pop && !flush && (count != '0);
  assign headData = (count != '0) ? mem[rdPtr] : '0;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + PTR_W'(1);
      if (popOk)  rdPtr <= rdPtr + PTR_W'(1);
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end

  // R2: occupancy never exceeds storage
  p_cap_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R2: push into a full FIFO leaves the count alone
  p_full_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush && count >= capWords) |=> $stable(count));
  // R5: flush empties
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/serfifo_dpath.sv
module serfifo_dpath import serfifo_pkg::*; #(
  parameter int FIFO_BYTES = 32,
  localparam int CNT_W = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [15:0]      wrWord,
  input  logic             engTxReq,
  input  logic             engRxValid,
  input  logic [15:0]      engRxWord,
  output logic [15:0]      engTxWord,
  output logic [15:0]      rxHead,
  output logic [CNT_W-1:0] txLevel,
  output logic [CNT_W-1:0] rxLevel,
  output logic [CNT_W-1:0] rxCount,
  output logic             txEnd,
  output logic             rxFull,
  output logic             txEmpty
);
  logic [CNT_W-1:0] capWords, txCount;
  logic [15:0] txIn, rxIn;

  assign capWords = strobes.wide ? CNT_W'(FIFO_BYTES / 2) : CNT_W'(FIFO_BYTES);
  assign txIn     = strobes.wide ? wrWord : {8'h00, wrWord[7:0]};
  assign rxIn     = strobes.wide ? engRxWord : {8'h00, engRxWord[7:0]};

  serfifo_fifo #(.DEPTH(FIFO_BYTES), .WIDTH(16)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(strobes.txPush), .pop(engTxReq),
    .flush(strobes.txFlush), .capWords(capWords), .wrData(txIn),
    .headData(engTxWord), .count(txCount));

  serfifo_fifo #(.DEPTH(FIFO_BYTES), .WIDTH(16)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(engRxValid), .pop(strobes.rxPop),
    .flush(strobes.rxFlush), .capWords(capWords), .wrData(rxIn),
    .headData(rxHead), .count(rxCount));

  assign txLevel = strobes.wide ? (txCount << 1) : txCount;
  assign rxLevel = strobes.wide ? (rxCount << 1) : rxCount;
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount >= capWords);
  assign txEnd   = engTxReq && !strobes.txFlush && (txCount == CNT_W'(1));
endmodule

// File: rtl/serfifo_ctrl.sv
module serfifo_ctrl import serfifo_pkg::*; #(
  parameter int FIFO_BYTES   = 32,
  parameter int TX_LOW_BYTES = 16,
  localparam int CNT_W    = $clog2(FIFO_BYTES + 1),
  localparam int MAX_CODE = $clog2(FIFO_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [5:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             engTxReq,
  input  logic             engRxValid,
  input  logic             engXferEnd,
  input  logic [CNT_W-1:0] txLevel,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [15:0]      rxHead,
  input  logic             txEnd,
  input  logic             rxFull,
  input  logic             txEmpty,
  output fifoStrobes_t     strobes,
  output logic             irq
);
  logic [2:0]  modeReg, trgReg;
  logic [31:0] ctrlReg, statReg, statNext, setEv, clrMask, rdMux;
  logic [CNT_W-1:0] thrWords;

  assign strobes.txPush  = regWr && (regAddr == OFS_TXWIN);
  assign strobes.txFlush = regWr && (regAddr == OFS_TXLVL);
  assign strobes.rxPop   = regRd && (regAddr == OFS_RXWIN);
  assign strobes.rxFlush = regWr && (regAddr == OFS_RXLVL);
  assign strobes.wide    = modeReg[M_WIDE];

  assign thrWords = (int'(trgReg) >= MAX_CODE) ? CNT_W'(FIFO_BYTES)
                                               : (CNT_W'(1) << trgReg);

  always_comb begin
    setEv = '0;
    setEv[B_RXTRG] = rxCount >= thrWords;
    setEv[B_TXTRG] = int'(txLevel) <= TX_LOW_BYTES;
    setEv[B_XEND]  = engXferEnd;
    setEv[B_TXEND] = txEnd;
    setEv[B_OVF]   = engRxValid && rxFull && modeReg[M_DUPLEX];
    setEv[B_UDR]   = engTxReq && txEmpty && modeReg[M_DUPLEX] && modeReg[M_RUN];
    clrMask  = (regWr && regAddr == OFS_STAT) ? regWrData : '0;
    statNext = ((statReg & ~clrMask) | setEv) & STAT_MASK;
    if (!ctrlReg[B_TRGEN]) statNext[B_RXTRG] = 1'b0;
  end

  always_comb begin
    unique case (regAddr)
      OFS_MODE:  rdMux = {29'b0, modeReg};
      OFS_CTRL:  rdMux = ctrlReg;
      OFS_STAT:  rdMux = statReg;
      OFS_RXLVL: rdMux = 32'(rxLevel);
      OFS_TXLVL: rdMux = 32'(txLevel);
      OFS_RXWIN: rdMux = {16'b0, rxHead};
      OFS_TRG:   rdMux = {29'b0, trgReg};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      trgReg    <= '0;
      ctrlReg   <= '0;
      statReg   <= '0;
      regRdData <= '0;
    end else begin
      statReg   <= statNext;
      regRdData <= regRd ? rdMux : '0;
      if (regWr && regAddr == OFS_MODE) modeReg <= regWrData[2:0];
      if (regWr && regAddr == OFS_TRG)  trgReg  <= regWrData[2:0];
      if (regWr && regAddr == OFS_CTRL) ctrlReg <= regWrData & CTRL_MASK;
    end
  end

  assign irq = |(statReg & ctrlReg & STAT_MASK);

  // R6: trigger status held low while its enable is off
  p_trg_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[B_TRGEN] |=> !statReg[B_RXTRG]);
  // R9: overflow captured in send-and-receive mode
  p_ovf_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (engRxValid && rxFull && modeReg[M_DUPLEX]) |=> statReg[B_OVF]);
  // R10: underrun captured while running in send-and-receive mode
  p_udr_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (engTxReq && txEmpty && modeReg[M_DUPLEX] && modeReg[M_RUN]) |=> statReg[B_UDR]);
  // R11: write-one clears transfer end when no new event arrives
  p_w1c_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFS_STAT && regWrData[B_XEND] && !engXferEnd) |=> !statReg[B_XEND]);
  // R8: transfer end pulse is captured
  p_xend_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    engXferEnd |=> statReg[B_XEND]);
endmodule

// File: rtl/serfifo_trig.sv
module serfifo_trig import serfifo_pkg::*; #(
  parameter int FIFO_BYTES   = 32,
  parameter int TX_LOW_BYTES = 16,
  localparam int CNT_W = $clog2(FIFO_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        engTxReq,
  output logic [15:0] engTxWord,
  input  logic        engRxValid,
  input  logic [15:0] engRxWord,
  input  logic        engXferEnd,
  output logic        irq
);
  fifoStrobes_t strobes;
  logic [15:0] rxHead;
  logic [CNT_W-1:0] txLevel, rxLevel, rxCount;
  logic txEnd, rxFull, txEmpty;

  serfifo_ctrl #(.FIFO_BYTES(FIFO_BYTES), .TX_LOW_BYTES(TX_LOW_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .engTxReq(engTxReq),
    .engRxValid(engRxValid), .engXferEnd(engXferEnd), .txLevel(txLevel),
    .rxLevel(rxLevel), .rxCount(rxCount), .rxHead(rxHead), .txEnd(txEnd),
    .rxFull(rxFull), .txEmpty(txEmpty), .strobes(strobes), .irq(irq));

  serfifo_dpath #(.FIFO_BYTES(FIFO_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrWord(regWrData[15:0]),
    .engTxReq(engTxReq), .engRxValid(engRxValid), .engRxWord(engRxWord),
    .engTxWord(engTxWord), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxCount(rxCount), .txEnd(txEnd), .rxFull(rxFull), .txEmpty(txEmpty));
endmodule

// File: tb/serfifo_trig_tb.sv
`timescale 1ns/1ps
module serfifo_trig_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0, engTxReq = 1'b0, engRxValid = 1'b0, engXferEnd = 1'b0;
  logic [31:0] regWrData = '0;
  logic [15:0] engRxWord = '0;
  logic [31:0] regRdData;
  logic [15:0] engTxWord;
  logic irq;

  always #2 clk = ~clk;

  serfifo_trig u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .engTxReq(engTxReq),
    .engTxWord(engTxWord), .engRxValid(engRxValid), .engRxWord(engRxWord),
    .engXferEnd(engXferEnd), .irq(irq));

  // reference model state
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  logic [2:0]  mMode, mTrg;
  logic [31:0] mCtrl, mStat, mRd;
  localparam logic [31:0] SMASK = 32'h0000_3311;
  localparam logic [31:0] CMASK = 32'h0008_3311;

  int nVec = 0, nBad = 0, cycles = 0;
  string phase = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      txq.delete(); rxq.delete();
      mMode = '0; mTrg = '0; mCtrl = '0; mStat = '0; mRd = '0;
    end else begin
      int txc, rxc, cap, thr, txl, rxl;
      logic [31:0] rd, setv, clr, nst;
      logic txFl, rxFl, txPop, txPush, rxPop, rxPush, wide;
      wide = mMode[0];
      cap = wide ? 16 : 32;
      txc = txq.size(); rxc = rxq.size();
      txl = wide ? 2 * txc : txc;
      rxl = wide ? 2 * rxc : rxc;
      rd = 0;
      if (regRd) begin
        case (regAddr)
          6'h00: rd = {29'b0, mMode};
          6'h08: rd = mCtrl;
          6'h0C: rd = mStat;
          6'h10: rd = rxl;
          6'h14: rd = txl;
          6'h18: rd = (rxc > 0) ? {16'b0, rxq[0]} : 32'b0;
          6'h20: rd = {29'b0, mTrg};
          default: rd = 0;
        endcase
      end
      txFl = regWr && regAddr == 6'h14;
      rxFl = regWr && regAddr == 6'h10;
      thr = (mTrg >= 5) ? 32 : (1 << mTrg);
      setv = 0;
      setv[0] = rxc >= thr;
      setv[4] = txl <= 16;
      setv[8] = engXferEnd;
      txPop = engTxReq && txc > 0 && !txFl;
      setv[9] = txPop && txc == 1;
      setv[12] = engRxValid && rxc >= cap && mMode[1];
      setv[13] = engTxReq && txc == 0 && mMode[1] && mMode[2];
      clr = (regWr && regAddr == 6'h0C) ? regWrData : 0;
      nst = ((mStat & ~clr) | setv) & SMASK;
      if (!mCtrl[19]) nst[0] = 1'b0;
      txPush = regWr && regAddr == 6'h1C && !txFl && txc < cap;
      rxPop = regRd && regAddr == 6'h18 && rxc > 0 && !rxFl;
      rxPush = engRxValid && rxc < cap && !rxFl;
      if (txFl) txq.delete();
      else begin
        if (txPop) void'(txq.pop_front());
        if (txPush) txq.push_back(wide ? regWrData[15:0] : {8'h00, regWrData[7:0]});
      end
      if (rxFl) rxq.delete();
      else begin
        if (rxPop) void'(rxq.pop_front());
        if (rxPush) rxq.push_back(wide ? engRxWord : {8'h00, engRxWord[7:0]});
      end
      if (regWr && regAddr == 6'h00) mMode = regWrData[2:0];
      if (regWr && regAddr == 6'h20) mTrg = regWrData[2:0];
      if (regWr && regAddr == 6'h08) mCtrl = regWrData & CMASK;
      mStat = nst;
      mRd = rd;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [15:0] expTx;
      logic expIrq;
      expTx = (txq.size() > 0) ? txq[0] : 16'h0;
      expIrq = |(mStat & mCtrl & SMASK);
      nVec++;
      if (regRdData !== mRd) begin
        nBad++;
        $display("FAIL %s regRdData got %h expected %h", phase, regRdData, mRd);
      end
      if (engTxWord !== expTx) begin
        nBad++;
        $display("FAIL %s engTxWord got %h expected %h", phase, engTxWord, expTx);
      end
      if (irq !== expIrq) begin
        nBad++;
        $display("FAIL %s irq got %b expected %b", phase, irq, expIrq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nBad++;
      $display("FAIL %s watchdog got hang expected completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic step(input logic w, input logic r, input logic [5:0] a,
                      input logic [31:0] d, input logic tq, input logic rv,
                      input logic [15:0] rw, input logic xe);
    regWr = w; regRd = r; regAddr = a; regWrData = d;
    engTxReq = tq; engRxValid = rv; engRxWord = rw; engXferEnd = xe;
    @(negedge clk);
  endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask
  task automatic rd(input logic [5:0] a);
    step(1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 6'h0, 32'h0, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask
  task automatic engRx(input logic [15:0] v);
    step(1'b0, 1'b0, 6'h0, 32'h0, 1'b0, 1'b1, v, 1'b0);
  endtask
  task automatic engTx();
    step(1'b0, 1'b0, 6'h0, 32'h0, 1'b1, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++) begin
      logic [5:0] a;
      int k;
      k = $urandom % 10;
      if (k < 4) a = 6'h1C;
      else if (k < 7) a = 6'h18;
      else if (k == 7) a = 6'h0C;
      else if (k == 8) a = 6'h08;
      else begin
        k = $urandom % 3;
        a = (k == 0) ? 6'h10 : (k == 1) ? 6'h14 : 6'h20;
      end
      step(($urandom % 3) == 0, ($urandom % 3) == 0, a, $urandom,
           ($urandom % 4) == 0, ($urandom % 3) == 0, 16'($urandom), ($urandom % 16) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phase = "R1";
    idle(2);
    rd(6'h00); rd(6'h08); rd(6'h0C); rd(6'h10); rd(6'h14); rd(6'h20);
    phase = "R13";
    rd(6'h04); rd(6'h3C); rd(6'h1C);
    wr(6'h00, 32'hFFFF_FFF5); rd(6'h00); wr(6'h20, 32'h0000_0013); rd(6'h20);
    wr(6'h00, 0); wr(6'h20, 0);
    phase = "R2";
    for (int i = 0; i < 35; i++) wr(6'h1C, 32'hA500 + i * 7);
    rd(6'h14);
    phase = "R3";
    for (int i = 0; i < 5; i++) engTx();
    rd(6'h14);
    phase = "R7";
    rd(6'h0C); wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C);
    phase = "R5";
    wr(6'h14, 32'h0); rd(6'h14);
    phase = "R2";
    wr(6'h00, 1);
    for (int i = 0; i < 18; i++) wr(6'h1C, 32'h1234_0000 + i * 257);
    rd(6'h14);
    phase = "R8";
    for (int i = 0; i < 18; i++) engTx();
    rd(6'h0C);
    step(1'b0, 1'b0, 6'h0, 0, 1'b0, 1'b0, 16'h0, 1'b1);
    rd(6'h0C); wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C);
    phase = "R4";
    wr(6'h00, 0);
    for (int i = 0; i < 34; i++) engRx(16'h3C00 + 16'(i));
    rd(6'h10);
    for (int i = 0; i < 5; i++) rd(6'h18);
    rd(6'h10);
    phase = "R5";
    wr(6'h10, 32'hDEAD); rd(6'h10);
    phase = "R4";
    rd(6'h18);
    wr(6'h00, 1);
    for (int i = 0; i < 3; i++) engRx(16'hBEE0 + 16'(i));
    rd(6'h18); rd(6'h18); rd(6'h10);
    phase = "R6";
    wr(6'h10, 0); wr(6'h00, 0);
    wr(6'h20, 2); rd(6'h0C);
    for (int i = 0; i < 3; i++) engRx(16'h0011);
    rd(6'h0C);
    engRx(16'h0022); rd(6'h0C); rd(6'h0C);
    wr(6'h08, 32'h0008_0001); rd(6'h0C); rd(6'h0C);
    wr(6'h08, 32'h0000_0001); idle(1); rd(6'h0C);
    wr(6'h10, 0); wr(6'h20, 7); wr(6'h08, 32'h0008_0001);
    for (int i = 0; i < 31; i++) engRx(16'(i));
    rd(6'h0C); engRx(16'h0077); rd(6'h0C); rd(6'h0C);
    wr(6'h08, 0); wr(6'h10, 0);
    phase = "R9";
    wr(6'h00, 0);
    for (int i = 0; i < 33; i++) engRx(16'(i));
    rd(6'h0C);
    wr(6'h00, 2); engRx(16'h00EE); rd(6'h0C);
    wr(6'h10, 0);
    phase = "R10";
    wr(6'h0C, 32'hFFFF_FFFF);
    engTx(); rd(6'h0C);
    wr(6'h00, 6); engTx(); rd(6'h0C);
    phase = "R11";
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C);
    step(1'b1, 1'b0, 6'h0C, 32'hFFFF_FFFF, 1'b0, 1'b0, 16'h0, 1'b1);
    rd(6'h0C);
    phase = "R12";
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08); idle(2);
    wr(6'h0C, 32'hFFFF_FFFF); idle(1);
    wr(6'h08, 32'h0000_2000); engTx(); idle(2);
    wr(6'h0C, 32'h0000_2000); idle(2); wr(6'h08, 0); wr(6'h00, 0);
    phase = "R7";
    for (int i = 0; i < 17; i++) wr(6'h1C, 32'(i));
    wr(6'h0C, 32'h10); rd(6'h0C); engTx(); idle(1); rd(6'h0C);
    wr(6'h14, 0);
    phase = "R3";
    wr(6'h00, 32'h6);
    randomRun(3000);
    phase = "R2";
    wr(6'h14, 0); wr(6'h10, 0); wr(6'h00, 32'h7);
    randomRun(3000);
    phase = "R4";
    wr(6'h00, 32'h0);
    randomRun(2000);
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule